// File: doc/BRIEF.md
# Parity-Checked Register Transfer Datapath

This block is the register-and-bus core of a microprogrammed processor. Each cycle a set of control-word fields selects one source for the A operand bus, one for the B operand bus, an ALU function and a destination register. The ALU result travels on a single result bus back to the chosen destination, and everything settles at one clock edge. Every byte carries an odd parity bit. Sources are checked as they are gated onto the operand buses. Results get freshly generated parity.

The A bus can take any of the eight registers or an external byte input. The B bus reaches only three registers, plus a constant zero. A narrowed path carries only the five low-order bits, and it can be used on the A source side, the destination side, or both. A dedicated address-transfer command copies the index register into the low address register and, in the same edge, clears the high address register.

Top module: `dp_bus_core`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, every register, `opa_q` and `opb_q` become data 0x00 with parity 1, and `carry_q`, `zero_q` and `perr_q` become 0.
- R2: Parity is odd: the 9-bit value {parity, data} holds an odd number of ones. Every register write produces correct parity for the data written, whatever the source parity was.
- R3: The A bus takes `ext_dat`/`ext_par` when `cw_a_ext`=1, and otherwise takes register `cw_a_sel`. On an active cycle its value is captured in `opa_q`.
- R4: The B bus takes `cw_b_sel` as follows: 0 gives the constant 0x00 with parity 1; 1, 2 and 3 give registers 5, 6 and 7. On an active cycle its value is captured in `opb_q`.
- R5: The `cw_fn` codes are 0 A, 1 A+B, 2 A-B, 3 A+B+carry, 4 AND, 5 OR, 6 XOR, 7 B. The 8-bit result is written to register `cw_dst` when `cw_dst_en`=1 and `cw_i2n`=0. Register k occupies `reg_q[9k+8:9k]` as {parity, data}.
- R6: Codes 1, 2 and 3 load `carry_q` with bit 8 of the 9-bit sum. Subtraction is A + ~B + 1, so a carry of 1 means no borrow. All other codes leave `carry_q` unchanged.
- R7: On every active cycle, `zero_q` is set to 1 when the 8-bit ALU result is zero and to 0 otherwise.
- R8: With `cw_a_narrow`=1, bits 7:5 of the A bus are zero, bits 4:0 come from the source, and the parity is recomputed over the resulting byte.
- R9: With `cw_dst_narrow`=1, the destination keeps its bits 7:5, takes bits 4:0 from the result, and gets parity recomputed over the merged byte.
- R10: With `cw_i2n`=1, register 1 receives register 2 with its parity, and register 0 becomes 0x00 with parity 1, both at the same edge. No other register, operand register or flag changes.
- R11: On an active cycle, a source with bad parity on the A or B bus sets `perr_q`. Once set, `perr_q` stays set until reset.
- R12: A cycle with `cw_dst_en`=0 and `cw_i2n`=0 changes no state. Bad parity on an unused or idle source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_a_sel | input | 3 | A-bus register select |
| cw_a_ext | input | 1 | A bus takes the external byte |
| cw_a_narrow | input | 1 | A bus passes only bits 4:0 |
| cw_b_sel | input | 2 | B-bus source code |
| cw_fn | input | 3 | ALU function code |
| cw_dst | input | 3 | Destination register |
| cw_dst_en | input | 1 | Perform an ALU transfer this cycle |
| cw_dst_narrow | input | 1 | Write only bits 4:0 of the destination |
| cw_i2n | input | 1 | Index-to-address transfer with high clear |
| ext_dat | input | 8 | External source data |
| ext_par | input | 1 | External source parity |
| reg_q | output | 72 | All registers, {parity, data} per 9-bit slot |
| opa_q | output | 9 | A operand register |
| opb_q | output | 9 | B operand register |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |
| perr_q | output | 1 | Sticky parity error flag |

## Verification
Some properties are checked on every cycle:
- stored parity stays odd in every register;
- the high address register reads zero after an index transfer;
- the parity flag is sticky;
- idle cycles and logic functions leave the held state alone;
- narrowed writes keep the upper destination bits;
- a narrowed A pass-through leaves zeros on top.

Other behaviour needs the bench's scenarios, which compare against a reference model:
- the exact arithmetic values and carry/borrow results;
- the B-bus source mapping;
- detection of an injected bad external parity;
- the interaction of narrowing on both sides;
- a register used as both source and destination.

// File: rtl/dp_pkg.sv
package dp_pkg;
    localparam int DW       = 8;
    localparam int PW       = DW + 1;
    localparam int NREG     = 8;
    localparam int RSW      = $clog2(NREG);
    localparam int NARROW_W = 5;
    localparam int BSRC     = 3;
    localparam int BSW      = $clog2(BSRC + 1);
    localparam int B_BASE   = NREG - BSRC;
    localparam int FNW      = 3;

    localparam logic [RSW-1:0] REG_AHI = RSW'(0);
    localparam logic [RSW-1:0] REG_ALO = RSW'(1);
    localparam logic [RSW-1:0] REG_IX  = RSW'(2);

    localparam logic [DW-1:0] LOW_MASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic          par;
        logic [DW-1:0] dat;
    } pbyte_t;

    typedef enum logic [FNW-1:0] {
        FN_PASSA = 3'd0,
        FN_ADD   = 3'd1,
        FN_SUB   = 3'd2,
        FN_ADDC  = 3'd3,
        FN_AND   = 3'd4,
        FN_OR    = 3'd5,
        FN_XOR   = 3'd6,
        FN_PASSB = 3'd7
    } alu_fn_t;

    function automatic pbyte_t mk_pb(input logic [DW-1:0] d);
        pbyte_t r;
        r.par = ~^d;
        r.dat = d;
        return r;
    endfunction

    function automatic logic par_ok(input pbyte_t b);
        return ^{b.par, b.dat};
    endfunction

    localparam pbyte_t ZERO_PB = '{par: 1'b1, dat: '0};
endpackage

// File: rtl/dp_srcmux.sv
module dp_srcmux
    import dp_pkg::*;
(
    input  pbyte_t [NREG-1:0] regs,
    input  logic [RSW-1:0]    a_sel,
    input  logic              a_ext,
    input  pbyte_t            ext_in,
    input  logic              a_narrow,
    input  logic [BSW-1:0]    b_sel,
    output pbyte_t            a_bus,
    output pbyte_t            b_bus,
    output logic              a_bad,
    output logic              b_bad
);
    pbyte_t a_raw;
    pbyte_t [BSRC:0] b_cand;

    assign a_raw = a_ext ? ext_in : regs[a_sel];
    assign a_bad = !par_ok(a_raw);
    assign a_bus = a_narrow ? mk_pb(a_raw.dat & LOW_MASK) : a_raw;

    assign b_cand[0] = ZERO_PB;
    for (genvar k = 0; k < BSRC; k++) begin : g_bsrc
        assign b_cand[k+1] = regs[B_BASE + k];
    end

    assign b_bus = b_cand[b_sel];
    assign b_bad = !par_ok(b_bus);
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
(
    input  pbyte_t  a,
    input  pbyte_t  b,
    input  alu_fn_t fn,
    input  logic    cin,
    output pbyte_t  z,
    output logic    cout,
    output logic    c_upd,
    output logic    is_zero
);
    logic [DW:0]   sum;
    logic [DW-1:0] res;

    always_comb begin
        sum   = '0;
        res   = '0;
        c_upd = 1'b0;
        unique case (fn)
            FN_PASSA: res = a.dat;
            FN_ADD: begin
                sum   = {1'b0, a.dat} + {1'b0, b.dat};
                res   = sum[DW-1:0];
                c_upd = 1'b1;
            end
            FN_SUB: begin
                sum   = {1'b0, a.dat} + {1'b0, ~b.dat} + {{DW{1'b0}}, 1'b1};
                res   = sum[DW-1:0];
                c_upd = 1'b1;
            end
            FN_ADDC: begin
                sum   = {1'b0, a.dat} + {1'b0, b.dat} + {{DW{1'b0}}, cin};
                res   = sum[DW-1:0];
                c_upd = 1'b1;
            end
            FN_AND:   res = a.dat & b.dat;
            FN_OR:    res = a.dat | b.dat;
            FN_XOR:   res = a.dat ^ b.dat;
            FN_PASSB: res = b.dat;
            default:  res = '0;
        endcase
    end

    assign cout    = sum[DW];
    assign is_zero = (res == '0);
    assign z       = mk_pb(res);
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
    import dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RSW-1:0]    wsel,
    input  logic              wnarrow,
    input  logic              i2n,
    input  pbyte_t            z,
    output pbyte_t [NREG-1:0] q
);
    pbyte_t mem [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        pbyte_t nxt;

        always_comb begin
            nxt = mem[k];
            if (i2n) begin
                if (RSW'(k) == REG_ALO)
                    nxt = mem[REG_IX];
                else if (RSW'(k) == REG_AHI)
                    nxt = ZERO_PB;
            end else if (we && wsel == RSW'(k)) begin
                nxt = wnarrow ? mk_pb((mem[k].dat & ~LOW_MASK) | (z.dat & LOW_MASK)) : z;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) mem[k] <= ZERO_PB;
            else     mem[k] <= nxt;
        end

        assign q[k] = mem[k];

        // R2: stored parity stays odd in every slot
        a_r2_stored_parity: assert property (@(posedge clk) disable iff (rst)
            par_ok(mem[k]));
    end

    // R10: the index transfer clears the high address register
    a_r10_hi_cleared: assert property (@(posedge clk) disable iff (rst)
        i2n |=> (mem[REG_AHI] == ZERO_PB));

    // R12: no write request leaves the whole file unchanged
    a_r12_file_hold: assert property (@(posedge clk) disable iff (rst)
        (!we && !i2n) |=> $stable(q));

    // R9: a narrowed write keeps the upper bits of its target
    a_r9_keep_upper: assert property (@(posedge clk) disable iff (rst)
        (we && !i2n && wnarrow) |=>
            (mem[$past(wsel)].dat[DW-1:NARROW_W] == $past(mem[wsel].dat[DW-1:NARROW_W])));
endmodule

// File: rtl/dp_bus_core.sv
module dp_bus_core
    import dp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RSW-1:0]       cw_a_sel,
    input  logic                 cw_a_ext,
    input  logic                 cw_a_narrow,
    input  logic [BSW-1:0]       cw_b_sel,
    input  logic [FNW-1:0]       cw_fn,
    input  logic [RSW-1:0]       cw_dst,
    input  logic                 cw_dst_en,
    input  logic                 cw_dst_narrow,
    input  logic                 cw_i2n,
    input  logic [DW-1:0]        ext_dat,
    input  logic                 ext_par,
    output logic [NREG*PW-1:0]   reg_q,
    output logic [PW-1:0]        opa_q,
    output logic [PW-1:0]        opb_q,
    output logic                 carry_q,
    output logic                 zero_q,
    output logic                 perr_q
);
    pbyte_t [NREG-1:0] regs;
    pbyte_t  ext_in, a_bus, b_bus, z_bus, opa_r, opb_r;
    logic    a_bad, b_bad, alu_cout, alu_cupd, alu_zero, go;
    alu_fn_t fn;

    assign fn     = alu_fn_t'(cw_fn);
    assign ext_in = '{par: ext_par, dat: ext_dat};
    assign go     = cw_dst_en && !cw_i2n;

    dp_srcmux u_src (
        .regs     (regs),
        .a_sel    (cw_a_sel),
        .a_ext    (cw_a_ext),
        .ext_in   (ext_in),
        .a_narrow (cw_a_narrow),
        .b_sel    (cw_b_sel),
        .a_bus    (a_bus),
        .b_bus    (b_bus),
        .a_bad    (a_bad),
        .b_bad    (b_bad)
    );

    dp_alu u_alu (
        .a       (a_bus),
        .b       (b_bus),
        .fn      (fn),
        .cin     (carry_q),
        .z       (z_bus),
        .cout    (alu_cout),
        .c_upd   (alu_cupd),
        .is_zero (alu_zero)
    );

    dp_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (cw_dst_en),
        .wsel    (cw_dst),
        .wnarrow (cw_dst_narrow),
        .i2n     (cw_i2n),
        .z       (z_bus),
        .q       (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_r   <= ZERO_PB;
            opb_r   <= ZERO_PB;
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
            perr_q  <= 1'b0;
        end else if (go) begin
            opa_r  <= a_bus;
            opb_r  <= b_bus;
            zero_q <= alu_zero;
            if (alu_cupd)      carry_q <= alu_cout;
            if (a_bad || b_bad) perr_q <= 1'b1;
        end
    end

    assign reg_q = regs;
    assign opa_q = opa_r;
    assign opb_q = opb_r;

    // R11: the parity error flag is sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        perr_q |=> perr_q);

    // R6: logic and pass functions hold the carry
    a_r6_carry_hold: assert property (@(posedge clk) disable iff (rst)
        (go && !(fn inside {FN_ADD, FN_SUB, FN_ADDC})) |=> $stable(carry_q));

    // R7: subtracting equal operands raises the zero flag
    a_r7_sub_equal: assert property (@(posedge clk) disable iff (rst)
        (go && fn == FN_SUB && a_bus.dat == b_bus.dat) |=> (zero_q && carry_q));

    // R8: a narrowed pass-through leaves the top bits clear
    a_r8_narrow_top: assert property (@(posedge clk) disable iff (rst)
        (go && cw_a_narrow) |=> (opa_q[DW-1:NARROW_W] == '0));

    // R12: idle cycles leave operands and flags alone
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cw_dst_en && !cw_i2n) |=>
            ($stable(opa_q) && $stable(opb_q) && $stable(perr_q) && $stable(zero_q)));
endmodule

// File: tb/tb_dp_bus_core.sv
`timescale 1ns/1ps
module tb_dp_bus_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cw_a_sel = '0;
    logic        cw_a_ext = 1'b0, cw_a_narrow = 1'b0;
    logic [1:0]  cw_b_sel = '0;
    logic [2:0]  cw_fn = '0, cw_dst = '0;
    logic        cw_dst_en = 1'b0, cw_dst_narrow = 1'b0, cw_i2n = 1'b0;
    logic [7:0]  ext_dat = '0;
    logic        ext_par = 1'b1;
    logic [71:0] reg_q;
    logic [8:0]  opa_q, opb_q;
    logic        carry_q, zero_q, perr_q;

    always #4 clk = ~clk;

    dp_bus_core dut (
        .clk(clk), .rst(rst), .cw_a_sel(cw_a_sel), .cw_a_ext(cw_a_ext),
        .cw_a_narrow(cw_a_narrow), .cw_b_sel(cw_b_sel), .cw_fn(cw_fn),
        .cw_dst(cw_dst), .cw_dst_en(cw_dst_en), .cw_dst_narrow(cw_dst_narrow),
        .cw_i2n(cw_i2n), .ext_dat(ext_dat), .ext_par(ext_par),
        .reg_q(reg_q), .opa_q(opa_q), .opb_q(opb_q),
        .carry_q(carry_q), .zero_q(zero_q), .perr_q(perr_q)
    );

    int total = 0;
    int bad = 0;
    logic [8:0] m_reg [8];
    logic [8:0] m_opa, m_opb;
    logic       m_cy, m_zf, m_perr;

    function automatic logic [8:0] pb(input logic [7:0] d);
        return {~^d, d};
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) m_reg[k] = 9'h100;
        m_opa = 9'h100; m_opb = 9'h100;
        m_cy = 1'b0; m_zf = 1'b0; m_perr = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        logic [71:0] ef;
        for (int k = 0; k < 8; k++) ef[k*9 +: 9] = m_reg[k];
        chk({tag, " registers"}, reg_q, ef);
        chk({tag, " operands"}, {54'd0, opa_q, opb_q}, {54'd0, m_opa, m_opb});
        chk({tag, " flags"}, {70'd0, carry_q, zero_q}, {70'd0, m_cy, m_zf});
        chk({tag, " parity-error"}, {71'd0, perr_q}, {71'd0, m_perr});
    endtask

    task automatic step(input string tag, input int asel, input bit aext, input bit anar,
                        input int bsel, input int fn, input int dst, input bit den,
                        input bit dnar, input bit i2n, input logic [8:0] ext9);
        logic [8:0] araw, abus, braw, s;
        logic [7:0] r;
        bit cu;
        cw_a_sel = 3'(asel); cw_a_ext = aext; cw_a_narrow = anar; cw_b_sel = 2'(bsel);
        cw_fn = 3'(fn); cw_dst = 3'(dst); cw_dst_en = den; cw_dst_narrow = dnar;
        cw_i2n = i2n; ext_par = ext9[8]; ext_dat = ext9[7:0];
        araw = aext ? ext9 : m_reg[asel];
        abus = anar ? pb(araw[7:0] & 8'h1F) : araw;
        braw = (bsel == 0) ? 9'h100 : m_reg[4 + bsel];
        s = '0; cu = 1'b0; r = '0;
        case (fn)
            0: r = abus[7:0];
            1: begin s = {1'b0, abus[7:0]} + {1'b0, braw[7:0]}; r = s[7:0]; cu = 1'b1; end
            2: begin s = {1'b0, abus[7:0]} + {1'b0, ~braw[7:0]} + 9'd1; r = s[7:0]; cu = 1'b1; end
            3: begin s = {1'b0, abus[7:0]} + {1'b0, braw[7:0]} + {8'd0, m_cy}; r = s[7:0]; cu = 1'b1; end
            4: r = abus[7:0] & braw[7:0];
            5: r = abus[7:0] | braw[7:0];
            6: r = abus[7:0] ^ braw[7:0];
            default: r = braw[7:0];
        endcase
        @(posedge clk);
        if (i2n) begin
            m_reg[1] = m_reg[2];
            m_reg[0] = 9'h100;
        end else if (den) begin
            m_opa = abus; m_opb = braw; m_zf = (r == 8'd0);
            if (cu) m_cy = s[8];
            if (!(^araw) || !(^braw)) m_perr = 1'b1;
            m_reg[dst] = dnar ? pb({m_reg[dst][7:5], r[4:0]}) : pb(r);
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic load(input int k, input logic [7:0] v);
        step("R3 load", 0, 1, 0, 0, 0, k, 1, 0, 0, pb(v));
    endtask

    task automatic op(input string tag, input int asel, input int bsel, input int fn, input int dst);
        step(tag, asel, 0, 0, bsel, fn, dst, 1, 0, 0, 9'h100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1 reset");

        load(0, 8'h3C); load(1, 8'hA5); load(2, 8'h7E); load(3, 8'h01);
        load(4, 8'h80); load(5, 8'h20); load(6, 8'hF0); load(7, 8'h0F);

        // R6: 0xF0 + 0x20 overflows
        op("R6 add carry", 6, 1, 1, 4);
        chk("R6 carry literal", {71'd0, carry_q}, 72'd1);
        chk("R2 parity literal", {63'd0, reg_q[4*9 +: 9]}, {63'd0, 9'h010});
        op("R6 logic holds carry", 6, 3, 4, 3);
        op("R6 addc", 6, 1, 3, 3);
        op("R6 sub borrow", 3, 2, 2, 3);
        op("R7 sub equal", 5, 1, 2, 4);
        chk("R7 zero literal", {70'd0, zero_q, carry_q}, {70'd0, 1'b1, 1'b1});
        op("R4 b zero", 2, 0, 7, 3);
        op("R4 b sel2", 0, 2, 5, 3);
        op("R4 b sel3", 1, 3, 6, 3);
        op("R5 pass b", 0, 1, 7, 2);
        op("R5 xor self", 5, 1, 6, 5);
        // R8: narrow A source
        step("R8 narrow source", 1, 0, 1, 0, 0, 3, 1, 0, 0, 9'h100);
        chk("R8 operand literal", {63'd0, opa_q}, {63'd0, pb(8'h05)});
        // R9: narrow destination, and both sides narrowed
        step("R9 narrow dest", 1, 0, 0, 0, 0, 6, 1, 1, 0, 9'h100);
        step("R9 both narrow", 0, 1, 1, 0, 0, 0, 1, 1, 0, pb(8'hFF));
        // R10
        step("R10 index transfer", 3, 0, 0, 2, 1, 7, 1, 0, 1, 9'h100);
        chk("R10 high cleared", {63'd0, reg_q[8:0]}, {63'd0, 9'h100});
        // R12: idle cycle with bad external parity
        step("R12 idle bad ext", 0, 1, 0, 1, 1, 5, 0, 0, 0, 9'h0FF ^ 9'h100 ^ 9'h100);
        step("R12 idle", 0, 1, 0, 2, 2, 6, 0, 1, 0, {1'b0, 8'h00});
        chk("R12 no error", {71'd0, perr_q}, 72'd0);

        for (int n = 0; n < 600; n++) begin
            logic [7:0] d;
            bit badp;
            d = 8'($urandom());
            badp = ($urandom() % 64) == 0;
            step("R2 R3 R4 R5 random",
                 int'($urandom() % 8), bit'($urandom() % 2), bit'(($urandom() % 4) == 0),
                 int'($urandom() % 4), int'($urandom() % 8), int'($urandom() % 8),
                 bit'(($urandom() % 8) != 0), bit'(($urandom() % 4) == 0),
                 bit'(($urandom() % 16) == 0), {pb(d)[8] ^ badp, d});
        end

        // R11: inject bad parity, then confirm it sticks
        rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
        compare_all("R1 R11 reset clears");
        step("R11 bad ext", 0, 1, 0, 0, 0, 2, 1, 0, 0, {1'b0, 8'h00});
        chk("R11 raised", {71'd0, perr_q}, 72'd1);
        op("R11 sticky", 2, 1, 1, 3);
        load(4, 8'h11);
        chk("R11 still set", {71'd0, perr_q}, 72'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule